// File: doc/BRIEF.md
# Actuator Homing Sequencer

This controller runs the start-up homing routine for a stepping actuator. The routine begins when the enable input rises and the routine-enable setting is on. It first waits through a lead-in, then issues a programmed number of steps in a primary direction, and then rests for a fixed standby. After the standby it issues a second programmed number of steps in the opposite direction. A 2-bit mode value selects the primary direction. The block drives one-clock step requests and a direction level to a downstream pulse generator, and it raises a busy flag for the full length of the routine.

Each part of the routine takes a whole number of step periods. One step period is a programmable number of clock cycles, counted inside the block. The block captures all settings in the cycle in which the routine starts, so changes made while the routine runs have no effect on it. If enable drops while the routine runs, the routine stops at once.

Top module: `homing_seq`

## Requirements
- R1: With the routine setting on and the block idle, a rising edge on `en_i` seen at a clock edge raises `busy_o` from that edge onward.
- R2: The routine opens with a lead-in of exactly one step period (P clocks) with no step request, so the first step request appears P clocks after `busy_o` rises.
- R3: The primary sweep issues INIT step requests spaced exactly P clocks apart, each with `dir_o` set to the primary direction.
- R4: After the primary sweep comes a standby of 4 step periods (4·P clocks), with no step request and `busy_o` held high.
- R5: The return sweep issues RET step requests P clocks apart in the direction opposite to the primary one. `busy_o` then falls, giving a total busy time of P·(5+INIT+RET) clocks.
- R6: The mode encoding is as follows. Mode 01 makes near (`dir_o`=1) the primary direction. Modes 00, 10 and 11 make far (`dir_o`=0) the primary direction.
- R7: With the routine setting off, a rising `en_i` leaves `busy_o` low and issues no step request.
- R8: Dropping `en_i` during the routine clears `busy_o` at the next clock edge, and no further step request follows.
- R9: The mode, period and step counts are captured when the routine starts. Changing them during the routine does not alter its timing or directions.
- R10: A zero value of the period, INIT or RET is treated as 1.
- R11: After the routine completes, holding `en_i` high does not restart it. Only a new rising edge does.
- R12: Each step request on `step_o` lasts one clock and is only ever issued while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; its rising edge starts the routine, and its falling edge aborts it |
| routine_on_i | input | 1 | Routine-enable setting |
| mode_i | input | 2 | Primary direction select (01 near, others far) |
| step_clks_i | input | PER_W | Clocks per step period (0 acts as 1) |
| init_steps_i | input | CNT_W | Primary sweep step count (0 acts as 1) |
| ret_steps_i | input | CNT_W | Return sweep step count (0 acts as 1) |
| busy_o | output | 1 | High while the routine runs |
| step_o | output | 1 | One-clock step request |
| dir_o | output | 1 | Direction for the step request: 0 far, 1 near |

## Verification
A wrong phase state or a miscounted phase length shows up as a step request in the wrong clock. It can also show up as a wrong direction, or as `busy_o` falling at the wrong time. Any of these is visible within one step period of the fault. A period counter that is off by one shifts every later step. The error grows with each step, so the first request after the lead-in already exposes it. Faulty capture of the settings shows up only when the inputs change mid-routine. For that reason the stimulus scrambles them while the routine is running.

// File: rtl/homing_pkg.sv
package homing_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_SWEEP  = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RETURN = 3'd4
    } phase_e;

    localparam int unsigned LEAD_PERIODS = 1;
    localparam int unsigned HOLD_PERIODS = 4;

    localparam logic DIR_FAR  = 1'b0;
    localparam logic DIR_NEAR = 1'b1;

    typedef struct packed {
        phase_e phase;
        logic   busy;
        logic   drive;
        logic   dir;
    } phase_ctl_t;

    function automatic logic primary_dir(input logic [1:0] mode);
        return (mode == 2'b01) ? DIR_NEAR : DIR_FAR;
    endfunction

endpackage

// File: rtl/homing_period_timer.sv
module homing_period_timer #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o,
    output logic             first_o
);
    localparam logic [PER_W-1:0] ONE = {{(PER_W-1){1'b0}}, 1'b1};

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] last_val;

    assign last_val = (period_i == '0) ? '0 : period_i - ONE;
    assign tick_o   = run_i && (cnt_q == last_val);
    assign first_o  = run_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R3
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= last_val));

endmodule

// File: rtl/homing_phase_counter.sv
module homing_phase_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    assign last_o = tick_i && (cnt_q == len_i - ONE);

    always_ff @(posedge clk) begin
        if (rst || !run_i || last_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/homing_phase_fsm.sv
module homing_phase_fsm
    import homing_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             routine_on_i,
    input  logic             prim_dir_i,
    input  logic [CNT_W-1:0] init_len_i,
    input  logic [CNT_W-1:0] ret_len_i,
    input  logic             phase_last_i,
    output phase_ctl_t       ctl_o,
    output logic             start_o,
    output logic [CNT_W-1:0] len_o
);
    localparam logic [CNT_W-1:0] LEAD_LEN = CNT_W'(LEAD_PERIODS);
    localparam logic [CNT_W-1:0] HOLD_LEN = CNT_W'(HOLD_PERIODS);
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    phase_e state_q, state_d;
    logic   en_q;

    assign start_o = en_i && !en_q && routine_on_i && (state_q == PH_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (start_o)      state_d = PH_LEAD;
            PH_LEAD:   if (phase_last_i) state_d = PH_SWEEP;
            PH_SWEEP:  if (phase_last_i) state_d = PH_HOLD;
            PH_HOLD:   if (phase_last_i) state_d = PH_RETURN;
            PH_RETURN: if (phase_last_i) state_d = PH_IDLE;
            default:                     state_d = PH_IDLE;
        endcase
        if (state_q != PH_IDLE && !en_i) begin
            state_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_i;
        end
    end

    always_comb begin
        unique case (state_q)
            PH_LEAD:   len_o = LEAD_LEN;
            PH_SWEEP:  len_o = init_len_i;
            PH_HOLD:   len_o = HOLD_LEN;
            PH_RETURN: len_o = ret_len_i;
            default:   len_o = ONE;
        endcase
    end

    always_comb begin
        ctl_o.phase = state_q;
        ctl_o.busy  = (state_q != PH_IDLE);
        ctl_o.drive = (state_q == PH_SWEEP) || (state_q == PH_RETURN);
        if (state_q == PH_SWEEP) begin
            ctl_o.dir = prim_dir_i;
        end else if (state_q == PH_RETURN) begin
            ctl_o.dir = ~prim_dir_i;
        end else begin
            ctl_o.dir = DIR_FAR;
        end
    end

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.busy && !en_i) |=> !ctl_o.busy);

    // R7
    routine_off_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !en_q && !routine_on_i && !ctl_o.busy) |=> !ctl_o.busy);

    // R4
    sweep_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_SWEEP && phase_last_i && en_i) |=> (state_q == PH_HOLD));

    // R5
    return_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_RETURN && phase_last_i) |=> !ctl_o.busy);

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_o |=> (state_q == PH_LEAD));

endmodule

// File: rtl/homing_seq.sv
module homing_seq
    import homing_pkg::*;
#(
    parameter int unsigned PER_W = 16,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             routine_on_i,
    input  logic [1:0]       mode_i,
    input  logic [PER_W-1:0] step_clks_i,
    input  logic [CNT_W-1:0] init_steps_i,
    input  logic [CNT_W-1:0] ret_steps_i,
    output logic             busy_o,
    output logic             step_o,
    output logic             dir_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [1:0]       mode_q;
    logic [PER_W-1:0] per_q;
    logic [CNT_W-1:0] init_q, ret_q;
    logic [CNT_W-1:0] init_eff, ret_eff, len;
    logic             start, tick, first, last;
    phase_ctl_t       ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 2'b00;
            per_q  <= '0;
            init_q <= '0;
            ret_q  <= '0;
        end else if (start) begin
            mode_q <= mode_i;
            per_q  <= step_clks_i;
            init_q <= init_steps_i;
            ret_q  <= ret_steps_i;
        end
    end

    assign init_eff = (init_q == '0) ? ONE : init_q;
    assign ret_eff  = (ret_q == '0) ? ONE : ret_q;

    homing_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .routine_on_i (routine_on_i),
        .prim_dir_i   (primary_dir(mode_q)),
        .init_len_i   (init_eff),
        .ret_len_i    (ret_eff),
        .phase_last_i (last),
        .ctl_o        (ctl),
        .start_o      (start),
        .len_o        (len)
    );

    homing_period_timer #(.PER_W(PER_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run_i    (ctl.busy),
        .period_i (per_q),
        .tick_o   (tick),
        .first_o  (first)
    );

    homing_phase_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctl.busy),
        .tick_i (tick),
        .len_i  (len),
        .last_o (last)
    );

    assign busy_o = ctl.busy;
    assign step_o = ctl.drive && first;
    assign dir_o  = ctl.dir;

    // R12
    step_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |-> busy_o);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> ($stable(per_q) && $stable(mode_q)));

    // R6
    dir_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.drive && ctl.phase == $past(ctl.phase)) |-> $stable(dir_o));

endmodule

// File: tb/homing_seq_bench.sv
module homing_seq_bench;
    localparam int PER_W = 16;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en_i = 1'b0;
    logic             routine_on_i = 1'b1;
    logic [1:0]       mode_i = 2'b00;
    logic [PER_W-1:0] step_clks_i = '0;
    logic [CNT_W-1:0] init_steps_i = '0;
    logic [CNT_W-1:0] ret_steps_i = '0;
    logic             busy_o, step_o, dir_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    homing_seq #(.PER_W(PER_W), .CNT_W(CNT_W)) u_homing_seq (
        .clk(clk), .rst(rst), .en_i(en_i), .routine_on_i(routine_on_i),
        .mode_i(mode_i), .step_clks_i(step_clks_i), .init_steps_i(init_steps_i),
        .ret_steps_i(ret_steps_i), .busy_o(busy_o), .step_o(step_o), .dir_o(dir_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit step_due(input int c, input int pe, input int ie, input int re);
        int base;
        base = pe * (5 + ie);
        if (c >= pe && c < pe * (1 + ie) && ((c - pe) % pe) == 0) return 1'b1;
        if (c >= base && c < base + pe * re && ((c - base) % pe) == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic run_seq(input logic [1:0] m, input int p, input int ii, input int rr,
                           input bit scramble);
        int  pe, ie, re, len, first_at, nsteps, busy_err, step_err, dir_err, extra;
        bit  prim, exp_s, exp_d;
        pe = (p == 0) ? 1 : p;
        ie = (ii == 0) ? 1 : ii;
        re = (rr == 0) ? 1 : rr;
        len = pe * (5 + ie + re);
        prim = (m == 2'b01);
        first_at = -1; nsteps = 0; busy_err = 0; step_err = 0; dir_err = 0; extra = 0;
        @(negedge clk);
        mode_i = m; step_clks_i = PER_W'(p); init_steps_i = CNT_W'(ii);
        ret_steps_i = CNT_W'(rr); routine_on_i = 1'b1; en_i = 1'b1;
        for (int c = 0; c < len + 4; c++) begin
            @(negedge clk);
            if (busy_o !== (c < len)) busy_err++;
            exp_s = step_due(c, pe, ie, re);
            if (step_o !== exp_s) step_err++;
            if (step_o === 1'b1) begin
                nsteps++;
                if (first_at < 0) first_at = c;
                exp_d = (c < pe * (1 + ie)) ? prim : !prim;
                if (dir_o !== exp_d) dir_err++;
            end
            if (scramble && c == 1) begin
                mode_i = ~m; step_clks_i = PER_W'(p + 3);
                init_steps_i = CNT_W'(ii + 2); ret_steps_i = CNT_W'(rr + 1);
            end
        end
        check(busy_err == 0, scramble ? "R9 R1 R5 busy window" : "R1 R4 R5 busy window", busy_err, 0);
        check(step_err == 0, scramble ? "R9 R3 R12 step timing" : "R3 R4 R12 step timing", step_err, 0);
        check(nsteps == ie + re, "R3 R5 R10 step count", nsteps, ie + re);
        check(first_at == pe, "R2 lead-in offset", first_at, pe);
        check(dir_err == 0, "R6 R3 R5 direction", dir_err, 0);
        repeat (8) begin
            @(negedge clk);
            if (busy_o !== 1'b0 || step_o !== 1'b0) extra++;
        end
        check(extra == 0, "R11 no restart while enable held", extra, 0);
        en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o === 1'b0 && step_o === 1'b0, "R1 reset state", busy_o, 0);

        // R6: every mode encoding
        run_seq(2'b00, 3, 2, 3, 1'b0);
        run_seq(2'b01, 3, 2, 3, 1'b0);
        run_seq(2'b10, 2, 3, 1, 1'b0);
        run_seq(2'b11, 2, 1, 2, 1'b0);
        // R10: zero values
        run_seq(2'b01, 0, 0, 0, 1'b0);
        run_seq(2'b00, 1, 0, 4, 1'b0);
        // R9: scrambled settings
        run_seq(2'b01, 4, 3, 2, 1'b1);

        // R7: routine switched off
        routine_on_i = 1'b0;
        en_i = 1'b1;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (busy_o !== 1'b0 || step_o !== 1'b0) bad++;
        end
        check(bad == 0, "R7 disabled routine stays idle", bad, 0);
        en_i = 1'b0;
        routine_on_i = 1'b1;
        @(negedge clk);

        // R8: abort in sweep and in standby
        for (int k = 0; k < 2; k++) begin
            step_clks_i = 3; init_steps_i = 5; ret_steps_i = 4; mode_i = 2'b00;
            en_i = 1'b1;
            repeat (k == 0 ? 7 : 20) @(negedge clk);
            check(busy_o === 1'b1, "R8 busy before abort", busy_o, 1);
            en_i = 1'b0;
            @(negedge clk);
            check(busy_o === 1'b0, "R8 busy cleared on abort", busy_o, 0);
            bad = 0;
            repeat (25) begin
                @(negedge clk);
                if (busy_o !== 1'b0 || step_o !== 1'b0) bad++;
            end
            check(bad == 0, "R8 no steps after abort", bad, 0);
        end

        // random routines
        for (int i = 0; i < 20; i++) begin
            run_seq(2'($urandom_range(0, 3)), int'($urandom_range(0, 5)),
                    int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
                    1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule